// File: doc/BRIEF.md
# Edge-Counting Pulse Accumulator

This block counts transitions on one bit of an external input byte. Every clock it samples the byte into an input latch. Bits 0 and 1 always follow the pins. The event bit (bit 7 by default) follows the pin only while a direction control marks that pin as an input. Bits 2 to 6 never follow the pins and hold their reset value.

When the event bit of the latch changes in the selected direction, an 8-bit counter advances by one. This happens only while counting is enabled and the gated-time mode is not selected. When the counter wraps to zero it raises a sticky overflow flag. The flag, ANDed with an interrupt-enable bit, drives an interrupt request. Software reaches the control byte, the count, the flag and the latched input through a small write/read register port.

Top module: `pacc_top`

## Requirements
- R1: After reset the control byte, the count, the overflow flag and the latched input all read 0, and `irq` is 0.
- R2: The count advances only when control bit 0 (enable) is 1 and control bit 1 (gated mode) is 0. A qualifying change of the pin is visible in the count one clock edge after the cycle in which it was presented.
- R3: With control bit 2 set, only 0-to-1 changes of the latched event bit advance the count. With bit 2 clear, only 1-to-0 changes advance it.
- R4: The count is 8 bits and wraps from 0xFF to 0x00. The overflow flag (bit 0 at address 2) is set exactly when an increment produces 0x00.
- R5: While control bit 3 (event pin is an output) is 1, pin changes on the event bit are ignored: the latched bit holds and no counting occurs. Latch bits 0 and 1 still follow the pins, and bits 2 to 6 never do. The latched input reads at address 3.
- R6: The overflow flag is sticky. Writing a 1 to bit 0 of address 2 clears it, and writing 0 has no effect. If a wrap and a clearing write fall in the same cycle, the flag ends set.
- R7: `irq` is 1 exactly while the overflow flag is 1 and control bit 4 (interrupt enable) is 1.
- R8: A write to the count (address 1) loads `wdata` and takes priority over an edge in the same cycle. Such a load never sets the overflow flag.
- R9: A write to address 0 stores control bits 4..0. Bits 7..5 of the control byte read as 0. `rdata` presents the register chosen by `addr` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ext_in | input | 8 | External input byte; bit 7 is the event pin |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select: 0 control, 1 count, 2 flag, 3 latched input |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the selected register |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle the assertions check the following:
- The count holds while counting is off.
- The count never moves by more than one step unless it is loaded.
- A count load lands exactly and never raises the flag.
- The flag only rises together with a zero count and stays up until it is cleared.
- The latched event bit holds while the pin is an output.

Only the bench scenarios can show the rest. That covers the direction of the counted edge, the wrap value, which latch bits follow the pins, the outcome when a wrap meets a clear, and the interrupt gating. The bench compares each of these against its own model on every clock.

// File: rtl/pacc_pkg.sv
package pacc_pkg;
  typedef enum logic [1:0] {
    RA_CTRL   = 2'd0,
    RA_COUNT  = 2'd1,
    RA_FLAG   = 2'd2,
    RA_SAMPLE = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic irq_en;
    logic pin_out;
    logic rise_sel;
    logic gated_mode;
    logic enable;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/pacc_rst_sync.sv
module pacc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/pacc_input_latch.sv
module pacc_input_latch #(
  parameter int              W           = 8,
  parameter int              EVT_BIT     = W - 1,
  parameter logic [W-1:0]    FOLLOW_MASK = 8'h03
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] ext_in,
  input  logic         pin_out,
  output logic [W-1:0] samp_q,
  output logic         evt_rise,
  output logic         evt_fall
);
  logic [W-1:0] mask;
  logic [W-1:0] samp_d;
  logic         samp_en;
  logic         evt_chg;

  // Per-bit follow mask: the event bit depends on the direction control.
  for (genvar b = 0; b < W; b++) begin : g_mask
    if (b == EVT_BIT) begin : g_evt
      assign mask[b] = ~pin_out;
    end else begin : g_fix
      assign mask[b] = FOLLOW_MASK[b];
    end
  end

  always_comb begin
    samp_d   = (ext_in & mask) | (samp_q & ~mask);
    samp_en  = |(samp_d ^ samp_q);
    evt_chg  = samp_d[EVT_BIT] ^ samp_q[EVT_BIT];
    evt_rise = evt_chg & samp_d[EVT_BIT];
    evt_fall = evt_chg & ~samp_d[EVT_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       samp_q <= '0;
    else if (samp_en) samp_q <= samp_d;
  end
endmodule

// File: rtl/pacc_counter.sv
module pacc_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] cnt_q,
  output logic             ovf_q
);
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;
  logic             wrap;
  logic             ovf_d;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (load) begin
      cnt_d  = load_val;
      cnt_en = 1'b1;
    end else if (step) begin
      cnt_d  = cnt_q + 1'b1;
      cnt_en = 1'b1;
    end
    wrap  = !load && step && (cnt_q == {CNT_W{1'b1}});
    ovf_d = ovf_q;
    if (wrap)          ovf_d = 1'b1;
    else if (flag_clr) ovf_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovf_q <= 1'b0;
    else        ovf_q <= ovf_d;
  end
endmodule

// File: rtl/pacc_regfile.sv
module pacc_regfile
  import pacc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic [CTRL_W-1:0] wdata_ctrl,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] cnt_val,
  input  logic              ovf_val,
  input  logic [DATA_W-1:0] samp_val,
  output ctrl_t             ctrl_q,
  output logic [DATA_W-1:0] rdata
);
  ctrl_t ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ctrl) ctrl_d = ctrl_t'(wdata_ctrl);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= ctrl_d;
  end

  always_comb begin
    unique case (addr)
      RA_CTRL:   rdata = {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};
      RA_COUNT:  rdata = cnt_val;
      RA_FLAG:   rdata = {{(DATA_W-1){1'b0}}, ovf_val};
      default:   rdata = samp_val;
    endcase
  end
endmodule

// File: rtl/pacc_top.sv
module pacc_top
  import pacc_pkg::*;
#(
  parameter int           DATA_W      = 8,
  parameter int           EVT_BIT     = DATA_W - 1,
  parameter logic [7:0]   FOLLOW_MASK = 8'h03
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] ext_in,
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  localparam logic [DATA_W-1:0] FOLLOW_W = DATA_W'(FOLLOW_MASK);

  logic              rst_sync_n;
  ctrl_t             ctrl_q;
  logic [DATA_W-1:0] samp_q;
  logic [DATA_W-1:0] cnt_q;
  logic              ovf_q;
  logic              evt_rise;
  logic              evt_fall;
  logic              wr_ctrl;
  logic              wr_cnt;
  logic              flag_clr;
  logic              cnt_on;
  logic              step;

  pacc_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  always_comb begin
    wr_ctrl  = wr_en && (addr == RA_CTRL);
    wr_cnt   = wr_en && (addr == RA_COUNT);
    flag_clr = wr_en && (addr == RA_FLAG) && wdata[0];
    cnt_on   = ctrl_q.enable && !ctrl_q.gated_mode;
    step     = cnt_on && (ctrl_q.rise_sel ? evt_rise : evt_fall);
  end

  pacc_input_latch #(
    .W           (DATA_W),
    .EVT_BIT     (EVT_BIT),
    .FOLLOW_MASK (FOLLOW_W)
  ) u_latch (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .ext_in   (ext_in),
    .pin_out  (ctrl_q.pin_out),
    .samp_q   (samp_q),
    .evt_rise (evt_rise),
    .evt_fall (evt_fall)
  );

  pacc_counter #(.CNT_W(DATA_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .step     (step),
    .load     (wr_cnt),
    .load_val (wdata),
    .flag_clr (flag_clr),
    .cnt_q    (cnt_q),
    .ovf_q    (ovf_q)
  );

  pacc_regfile #(.DATA_W(DATA_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .wr_ctrl    (wr_ctrl),
    .wdata_ctrl (wdata[CTRL_W-1:0]),
    .addr       (addr),
    .cnt_val    (cnt_q),
    .ovf_val    (ovf_q),
    .samp_val   (samp_q),
    .ctrl_q     (ctrl_q),
    .rdata      (rdata)
  );

  assign irq = ovf_q && ctrl_q.irq_en;
endmodule

// File: rtl/pacc_chk.sv
module pacc_chk #(
  parameter int DATA_W  = 8,
  parameter int EVT_BIT = DATA_W - 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [1:0]        addr,
  input logic [DATA_W-1:0] wdata,
  input logic              en,
  input logic              gated,
  input logic              pin_out,
  input logic [DATA_W-1:0] cnt_q,
  input logic              ovf_q,
  input logic [DATA_W-1:0] samp_q
);
  logic              ld;
  logic              clr;
  logic [DATA_W-1:0] cnt_next1;

  assign ld        = wr_en && (addr == 2'd1);
  assign clr       = wr_en && (addr == 2'd2) && wdata[0];
  assign cnt_next1 = cnt_q + 1'b1;

  // R2: counting off means the count holds unless loaded
  a_r2_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!(en && !gated) && !ld) |=> $stable(cnt_q));

  // R4: without a load the count moves by at most one step
  a_r4_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    !ld |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_next1)));

  // R4: the flag only rises together with a zero count
  a_r4_flag_on_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_q) |-> (cnt_q == '0));

  // R5: latched event bit holds while the pin is an output
  a_r5_pin_hold: assert property (@(posedge clk) disable iff (!rst_n)
    pin_out |=> (samp_q[EVT_BIT] == $past(samp_q[EVT_BIT])));

  // R6: flag stays set unless a clearing write arrives
  a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !clr) |=> ovf_q);

  // R8: a count load lands exactly and never raises the flag
  a_r8_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (cnt_q == $past(wdata) && !$rose(ovf_q)));
endmodule

bind pacc_top pacc_chk #(.DATA_W(DATA_W), .EVT_BIT(EVT_BIT)) u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .wr_en   (wr_en),
  .addr    (addr),
  .wdata   (wdata),
  .en      (ctrl_q.enable),
  .gated   (ctrl_q.gated_mode),
  .pin_out (ctrl_q.pin_out),
  .cnt_q   (cnt_q),
  .ovf_q   (ovf_q),
  .samp_q  (samp_q)
);

// File: tb/tb_pacc_top.sv
`timescale 1ns/1ps
module tb_pacc_top;
  logic       clk;
  logic       rst_n;
  logic [7:0] ext_in;
  logic       wr_en;
  logic [1:0] addr;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic       irq;

  int vectors = 0;
  int miscompares = 0;
  string cur_req = "R1";

  // behavioural reference state
  int m_port, m_cnt, m_ctrl, m_flag, cur_ext;

  pacc_top dut (
    .clk(clk), .rst_n(rst_n), .ext_in(ext_in), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog %s: actual=timeout expected=completion", cur_req);
    finish_run();
  end

  function automatic int exp_read(int a);
    case (a)
      0: return m_ctrl;
      1: return m_cnt;
      2: return m_flag;
      default: return m_port;
    endcase
  endfunction

  task automatic model(int e, int w, int a, int d);
    int mask, np, inc, was;
    mask = ((m_ctrl >> 3) & 1) ? 'h03 : 'h83;
    np   = (e & mask) | (m_port & ~mask & 'hFF);
    inc  = 0;
    if ((m_ctrl & 1) && !((m_ctrl >> 1) & 1) && (((np ^ m_port) >> 7) & 1)) begin
      if ((m_ctrl >> 2) & 1) inc = (np >> 7) & 1;
      else                   inc = !((np >> 7) & 1);
    end
    was = 0;
    if (w && a == 1) m_cnt = d;
    else if (inc) begin
      m_cnt = (m_cnt + 1) % 256;
      if (m_cnt == 0) was = 1;
    end
    if (was) m_flag = 1;
    else if (w && a == 2 && (d & 1)) m_flag = 0;
    if (w && a == 0) m_ctrl = d & 'h1F;
    m_port = np;
  endtask

  task automatic compare();
    int er, ei;
    er = exp_read(int'(addr));
    ei = m_flag & ((m_ctrl >> 4) & 1);
    vectors++;
    if (int'(rdata) != er) begin
      miscompares++;
      $display("FAIL %s rdata addr=%0d: actual=%02h expected=%02h", cur_req, addr, rdata, er);
    end
    if (int'(irq) != ei) begin
      miscompares++;
      $display("FAIL %s irq: actual=%0d expected=%0d", cur_req, irq, ei);
    end
  endtask

  task automatic cyc(int e, int w, int a, int d);
    ext_in = 8'(e); wr_en = (w != 0); addr = 2'(a); wdata = 8'(d);
    cur_ext = e;
    @(posedge clk);
    model(e, w, a, d);
    @(negedge clk);
    compare();
  endtask

  task automatic wr(int a, int d); cyc(cur_ext, 1, a, d); endtask
  task automatic rd(int a);        cyc(cur_ext, 0, a, 0); endtask
  task automatic pin(int e, int a); cyc(e, 0, a, 0); endtask

  initial begin
    rst_n = 1'b0; ext_in = '0; wr_en = 1'b0; addr = '0; wdata = '0;
    m_port = 0; m_cnt = 0; m_ctrl = 0; m_flag = 0; cur_ext = 0;
    repeat (3) @(posedge clk);
    // R1: reset values at every address
    for (int a = 0; a < 4; a++) begin
      @(negedge clk); addr = 2'(a); #1; compare();
    end
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < 3; i++) cyc(0, 0, 1, 0);

    // R9: control readback masks upper bits
    cur_req = "R9";
    wr(0, 'hFF); rd(0); wr(0, 'h00); rd(0);

    // R2: disabled, then gated mode selected: no counting
    cur_req = "R2";
    for (int i = 0; i < 4; i++) begin pin('h80, 1); pin('h00, 1); end
    wr(0, 'h03);
    for (int i = 0; i < 4; i++) begin pin('h80, 1); pin('h00, 3); end
    wr(0, 'h01); pin('h80, 1); pin('h00, 1); rd(1);

    // R3: falling edges only, then rising only
    cur_req = "R3";
    for (int i = 0; i < 3; i++) begin pin('h80, 1); pin('h00, 1); end
    wr(0, 'h05);
    for (int i = 0; i < 3; i++) begin pin('h80, 1); pin('h00, 1); end

    // R4: wrap and flag
    cur_req = "R4";
    wr(1, 'hFE); rd(2);
    pin('h80, 1); rd(2); pin('h00, 1);
    pin('h80, 2); rd(1);

    // R7: interrupt gating
    cur_req = "R7";
    wr(0, 'h15); rd(2); wr(0, 'h05); rd(2); wr(0, 'h15);

    // R6: write 0 keeps, write 1 clears, set beats clear
    cur_req = "R6";
    wr(2, 0); rd(2); wr(2, 1); rd(2);
    wr(1, 'hFF); pin('h00, 2);
    cyc('h80, 1, 2, 1); rd(2); wr(2, 1); rd(2);

    // R5: pin as output ignores bit 7; bits 0,1 follow; 2..6 never
    cur_req = "R5";
    wr(0, 'h0D);
    pin('h00, 3); pin('hFF, 3); pin('h00, 1); pin('h7E, 3); pin('hFF, 1);
    wr(0, 'h05); pin('h00, 3); pin('h80, 3); rd(1);

    // R8: load beats a simultaneous edge; load never flags
    cur_req = "R8";
    pin('h00, 1);
    cyc('h80, 1, 1, 'h42); rd(1);
    cyc('h00, 1, 1, 'hFF); cyc('h80, 1, 1, 'h00); rd(2);

    // R2: mixed random traffic
    cur_req = "R2";
    for (int i = 0; i < 3000; i++) begin
      int w;
      w = (($urandom % 8) == 0) ? 1 : 0;
      cyc(int'($urandom % 256), w, int'($urandom % 4), int'($urandom % 256));
    end

    finish_run();
  end
endmodule